// File: doc/BRIEF.md
# Serial Control Slave with Echo-Back

This block is the serial control port of a processing core. A host selects it with an active-low chip select and clocks in a frame of bits, most significant bit first. The frame opens with a command byte. The top bit of that byte says whether the host writes or only reads. The lower seven bits name a target area. For an area that has addresses, a 16-bit start address follows, and then a stream of data words. The word length depends on the area. Each complete word leaves the block as a one-cycle write strobe on a plain valid/area/address/data port. The address then advances by one, so a burst fills consecutive locations.

While the frame runs, the serial output plays back every input bit exactly eight serial clocks late. This lets the host confirm what it sent. To see the echo of the last word, the host clocks eight trailing bits. If the trailing bits make up a full word, that word is written at the next address like any other. Between frames the output is either released (output enable low) or driven low, as selected by a static configuration input.

All logic runs on the system clock. The serial clock, chip select and data input are treated as signals that are already synchronous to it, and serial clock edges are found by comparing each sample with the previous one.

Top module: `sctl_echo_slave`

## Requirements
- R1: The first 8 bits after chip select falls form the command byte, MSB first. Command bit 7 = 1 marks a write frame. With bit 7 = 0 the frame never raises `wr_valid`.
- R2: Command bits 6:0 select the area. Code 7'h34 selects 24-bit words with a 16-bit address. Code 7'h35 selects 16-bit words with a 16-bit address. Any other code has no address and no data, and nothing clocked after that command is ever written.
- R3: In an addressed area, the 16 bits after the command are the start address, MSB first, and the first data word is written to that address.
- R4: Each complete data word of a write frame gives exactly one cycle of `wr_valid`, with `wr_area` equal to the command's area code, `wr_addr` equal to the current address and the word in `wr_data` (a 16-bit word sits in bits 15:0 with bits 23:16 zero). The address then rises by one, wrapping from 16'hFFFF to 16'h0000.
- R5: Bits of an incomplete word that are pending when chip select rises are discarded, with no strobe.
- R6: Trailing bits clocked after the intended data that reach a full word length are written as a further word at the next address.
- R7: During a frame `spi_dout_oe` is 1. After the falling serial clock edge that follows the n-th sampled bit, `spi_dout` carries the bit sampled at rising edge n-7, so the host reads each bit 8 clocks after sending it. The output is 0 before eight bits have been sampled, and it changes only while the serial clock is low.
- R8: While chip select is high, `spi_dout` is 0 and `spi_dout_oe` equals `idle_low_cfg` (1 = drive low, 0 = released).
- R9: Chip select rising at any bit position clears the frame state and the echo delay line, so the next frame starts with a command byte and an all-zero echo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_low_cfg | input | 1 | Idle output mode: 1 drives low, 0 releases |
| spi_cs_n | input | 1 | Active-low chip select, synchronous to clk |
| spi_clk | input | 1 | Serial clock, idle low, synchronous to clk |
| spi_din | input | 1 | Serial data in, sampled on serial clock rise |
| spi_dout | output | 1 | Serial data out (echo) |
| spi_dout_oe | output | 1 | Output enable for spi_dout |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_area | output | 7 | Area code of the write |
| wr_addr | output | 16 | Write address |
| wr_data | output | 24 | Write data, right-aligned |

## Verification
The final bit of a data word is used twice at the same rising serial edge. It completes the word and raises a write strobe, and it also enters the echo delay line that drives the output eight clocks later. The bench runs write bursts with trailing bits while a scoreboard compares every strobe against the words it expects. At the same time it compares every output bit against the stream it sent eight bits earlier. It repeats this with 16-bit words that cross the address wrap and end with a full trailing word. A fault in either path then shows up in the same frame as a strobe mismatch or an echo mismatch.

// File: rtl/sctl_pkg.sv
// Package: shared types for the serial control slave.
// Assumes: nothing beyond IEEE 1800-2017.
package sctl_pkg;

    // Field currently being shifted in within a frame
    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

endpackage

// File: rtl/sctl_sclk_edge.sv
// Module: sctl_sclk_edge
// Finds rising and falling serial clock edges by comparing each system clock
// sample with the previous one. Edges are reported only while chip select is low.
// Assumes: spi_clk and spi_cs_n are already synchronous to clk, and each serial
// clock phase lasts at least two system clock cycles.
module sctl_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_clk,
    output logic frame_on,
    output logic bit_rise,
    output logic bit_fall
);

    logic sclk_q;

    // Keep the previous serial clock level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= spi_clk;
        end
    end

    // Edge pulses, gated by an active frame
    always_comb begin
        frame_on = ~spi_cs_n;
        bit_rise = frame_on &  spi_clk & ~sclk_q;
        bit_fall = frame_on & ~spi_clk &  sclk_q;
    end

endmodule

// File: rtl/sctl_echo_line.sv
// Module: sctl_echo_line
// Delays the input bit stream by DEPTH serial clocks and drives it out.
// The output updates on falling serial edges, and the idle output level is
// chosen by idle_low.
// Assumes: bit_rise and bit_fall are single-cycle pulses that are never
// raised together.
module sctl_echo_line #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_on,
    input  logic bit_rise,
    input  logic bit_fall,
    input  logic din,
    input  logic idle_low,
    output logic dout,
    output logic dout_oe
);

    logic [DEPTH-1:0] dly_q;
    logic             dout_q;

    // Shift in on rise, present the oldest bit on fall, clear between frames
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_on) begin
            dly_q  <= '0;
            dout_q <= 1'b0;
        end else begin
            if (bit_rise) begin
                dly_q <= {dly_q[DEPTH-2:0], din};
            end
            if (bit_fall) begin
                dout_q <= dly_q[DEPTH-1];
            end
        end
    end

    // Pin level: echo in a frame, low or released between frames
    always_comb begin
        dout    = frame_on ? dout_q : 1'b0;
        dout_oe = frame_on | idle_low;
    end

endmodule

// File: rtl/sctl_cmd_decode.sv
// Module: sctl_cmd_decode
// Small lookup from area code to "has address" and word length.
// Assumes: LONG_CODE differs from SHORT_CODE, and both lengths fit in CNT_W bits.
module sctl_cmd_decode #(
    parameter int          AREA_W     = 7,
    parameter int          CNT_W      = 5,
    parameter logic [6:0]  LONG_CODE  = 7'h34,
    parameter logic [6:0]  SHORT_CODE = 7'h35,
    parameter int          LONG_LEN   = 24,
    parameter int          SHORT_LEN  = 16
) (
    input  logic [AREA_W-1:0] area,
    output logic              has_addr,
    output logic [CNT_W-1:0]  word_len
);

    localparam logic [AREA_W-1:0] LONG_A  = AREA_W'(LONG_CODE);
    localparam logic [AREA_W-1:0] SHORT_A = AREA_W'(SHORT_CODE);

    // Area code to address presence and word length
    always_comb begin
        has_addr = 1'b0;
        word_len = '0;
        if (area == LONG_A) begin
            has_addr = 1'b1;
            word_len = CNT_W'(LONG_LEN);
        end else if (area == SHORT_A) begin
            has_addr = 1'b1;
            word_len = CNT_W'(SHORT_LEN);
        end
    end

endmodule

// File: rtl/sctl_frame_ctrl.sv
// Module: sctl_frame_ctrl
// Walks a frame through command, address and data fields. It assembles each
// field MSB first and raises a one-cycle write strobe per complete data word
// of a write frame, then steps the address.
// Assumes: bit_rise is a single-cycle pulse per serial bit, and frame_on low
// resets the frame state.
module sctl_frame_ctrl
    import sctl_pkg::*;
#(
    parameter int          CMD_W      = 8,
    parameter int          ADDR_W     = 16,
    parameter int          WMAX       = 24,
    parameter int          CNT_W      = 5,
    parameter logic [6:0]  LONG_CODE  = 7'h34,
    parameter logic [6:0]  SHORT_CODE = 7'h35,
    parameter int          LONG_LEN   = 24,
    parameter int          SHORT_LEN  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_on,
    input  logic                bit_rise,
    input  logic                din,
    output logic                wr_valid,
    output logic [CMD_W-2:0]    wr_area,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [WMAX-1:0]     wr_data
);

    localparam int AREA_W = CMD_W - 1;
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);

    phase_e              phase_q;
    logic [CNT_W-1:0]    bit_cnt_q;
    logic [WMAX-1:0]     shreg_q;
    logic [WMAX-1:0]     sh_next;
    logic                is_wr_q;
    logic [AREA_W-1:0]   area_q;
    logic [CNT_W-1:0]    word_len_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                dec_has_addr;
    logic [CNT_W-1:0]    dec_len;
    logic                wr_valid_q;
    logic [ADDR_W-1:0]   wr_addr_q;
    logic [WMAX-1:0]     wr_data_q;

    // Shift register value including the bit sampled at this edge
    always_comb begin
        sh_next = {shreg_q[WMAX-2:0], din};
    end

    sctl_cmd_decode #(
        .AREA_W     (AREA_W),
        .CNT_W      (CNT_W),
        .LONG_CODE  (LONG_CODE),
        .SHORT_CODE (SHORT_CODE),
        .LONG_LEN   (LONG_LEN),
        .SHORT_LEN  (SHORT_LEN)
    ) u_dec (
        .area     (sh_next[AREA_W-1:0]),
        .has_addr (dec_has_addr),
        .word_len (dec_len)
    );

    // Frame field sequencing, address stepping and write strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_on) begin
            phase_q    <= PH_CMD;
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
            is_wr_q    <= 1'b0;
            area_q     <= '0;
            word_len_q <= '0;
            addr_q     <= '0;
            wr_valid_q <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end else begin
            wr_valid_q <= 1'b0;
            if (bit_rise) begin
                case (phase_q)
                    PH_CMD: begin
                        if (bit_cnt_q == CMD_LAST) begin
                            is_wr_q    <= sh_next[CMD_W-1];
                            area_q     <= sh_next[AREA_W-1:0];
                            word_len_q <= dec_len;
                            phase_q    <= dec_has_addr ? PH_ADDR : PH_SKIP;
                            bit_cnt_q  <= '0;
                            shreg_q    <= '0;
                        end else begin
                            bit_cnt_q  <= bit_cnt_q + 1'b1;
                            shreg_q    <= sh_next;
                        end
                    end
                    PH_ADDR: begin
                        if (bit_cnt_q == ADDR_LAST) begin
                            addr_q    <= sh_next[ADDR_W-1:0];
                            phase_q   <= PH_DATA;
                            bit_cnt_q <= '0;
                            shreg_q   <= '0;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            shreg_q   <= sh_next;
                        end
                    end
                    PH_DATA: begin
                        if (bit_cnt_q == word_len_q - 1'b1) begin
                            wr_valid_q <= is_wr_q;
                            wr_addr_q  <= addr_q;
                            wr_data_q  <= sh_next;
                            addr_q     <= addr_q + 1'b1;
                            bit_cnt_q  <= '0;
                            shreg_q    <= '0;
                        end else begin
                            bit_cnt_q  <= bit_cnt_q + 1'b1;
                            shreg_q    <= sh_next;
                        end
                    end
                    default: begin
                        phase_q <= PH_SKIP;
                    end
                endcase
            end
        end
    end

    // Write port outputs
    always_comb begin
        wr_valid = wr_valid_q;
        wr_area  = area_q;
        wr_addr  = wr_addr_q;
        wr_data  = wr_data_q;
    end

endmodule

// File: rtl/sctl_echo_slave.sv
// Module: sctl_echo_slave (top)
// Serial control slave: a command byte, an optional 16-bit address and data
// words become write strobes on a memory-style port, and the serial output
// echoes the input ECHO_DEPTH bits late.
// Assumes: serial inputs are synchronous to clk, each serial clock phase lasts
// at least two clk cycles, and the serial clock is low when chip select changes.
module sctl_echo_slave #(
    parameter int          CMD_W      = 8,
    parameter int          ADDR_W     = 16,
    parameter int          LONG_LEN   = 24,
    parameter int          SHORT_LEN  = 16,
    parameter int          ECHO_DEPTH = 8,
    parameter logic [6:0]  LONG_CODE  = 7'h34,
    parameter logic [6:0]  SHORT_CODE = 7'h35
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idle_low_cfg,
    input  logic                spi_cs_n,
    input  logic                spi_clk,
    input  logic                spi_din,
    output logic                spi_dout,
    output logic                spi_dout_oe,
    output logic                wr_valid,
    output logic [CMD_W-2:0]    wr_area,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [LONG_LEN-1:0] wr_data
);

    localparam int WMAX  = LONG_LEN;
    localparam int MAXF  = (ADDR_W > WMAX) ? ADDR_W : WMAX;
    localparam int CNT_W = $clog2(MAXF + 1);

    logic frame_on;
    logic bit_rise;
    logic bit_fall;

    sctl_sclk_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (spi_cs_n),
        .spi_clk  (spi_clk),
        .frame_on (frame_on),
        .bit_rise (bit_rise),
        .bit_fall (bit_fall)
    );

    sctl_echo_line #(
        .DEPTH (ECHO_DEPTH)
    ) u_echo (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_on (frame_on),
        .bit_rise (bit_rise),
        .bit_fall (bit_fall),
        .din      (spi_din),
        .idle_low (idle_low_cfg),
        .dout     (spi_dout),
        .dout_oe  (spi_dout_oe)
    );

    sctl_frame_ctrl #(
        .CMD_W      (CMD_W),
        .ADDR_W     (ADDR_W),
        .WMAX       (WMAX),
        .CNT_W      (CNT_W),
        .LONG_CODE  (LONG_CODE),
        .SHORT_CODE (SHORT_CODE),
        .LONG_LEN   (LONG_LEN),
        .SHORT_LEN  (SHORT_LEN)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_on (frame_on),
        .bit_rise (bit_rise),
        .din      (spi_din),
        .wr_valid (wr_valid),
        .wr_area  (wr_area),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

endmodule

// File: rtl/sctl_echo_checker.sv
// Module: sctl_echo_checker
// Port-level properties of the serial control slave, bound to the top module.
// Assumes: the same parameters as the top module.
module sctl_echo_checker #(
    parameter int          AREA_W     = 7,
    parameter int          ADDR_W     = 16,
    parameter int          LONG_LEN   = 24,
    parameter int          SHORT_LEN  = 16,
    parameter logic [6:0]  LONG_CODE  = 7'h34,
    parameter logic [6:0]  SHORT_CODE = 7'h35
) (
    input logic                clk,
    input logic                rst_n,
    input logic                idle_low_cfg,
    input logic                spi_cs_n,
    input logic                spi_clk,
    input logic                spi_dout,
    input logic                spi_dout_oe,
    input logic                wr_valid,
    input logic [AREA_W-1:0]   wr_area,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [LONG_LEN-1:0] wr_data
);

    logic              seen_q;
    logic [ADDR_W-1:0] last_q;

    // Remember the previous write address within the current frame
    always_ff @(posedge clk) begin
        if (!rst_n || spi_cs_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (wr_valid) begin
            seen_q <= 1'b1;
            last_q <= wr_addr;
        end
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (spi_dout == 1'b0 && spi_dout_oe == idle_low_cfg)); // R8

    AST_FRAME_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> spi_dout_oe); // R7

    AST_ECHO_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(spi_dout) && !spi_cs_n && $past(!spi_cs_n)) |-> !spi_clk); // R7

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && seen_q) |-> wr_addr == ADDR_W'(last_q + 1'b1)); // R4

    AST_AREA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_area == AREA_W'(LONG_CODE) || wr_area == AREA_W'(SHORT_CODE))); // R2

    AST_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_area == AREA_W'(SHORT_CODE)) |-> wr_data[LONG_LEN-1:SHORT_LEN] == '0); // R4

    AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> !wr_valid); // R9

endmodule

bind sctl_echo_slave sctl_echo_checker #(
    .AREA_W     (CMD_W - 1),
    .ADDR_W     (ADDR_W),
    .LONG_LEN   (LONG_LEN),
    .SHORT_LEN  (SHORT_LEN),
    .LONG_CODE  (LONG_CODE),
    .SHORT_CODE (SHORT_CODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .idle_low_cfg (idle_low_cfg),
    .spi_cs_n     (spi_cs_n),
    .spi_clk      (spi_clk),
    .spi_dout     (spi_dout),
    .spi_dout_oe  (spi_dout_oe),
    .wr_valid     (wr_valid),
    .wr_area      (wr_area),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data)
);

// File: tb/sim_sctl_echo_slave.sv
// Bench for sctl_echo_slave: a scoreboard of expected writes plus a bitwise
// echo model kept in the driver.
module sim_sctl_echo_slave;

    logic        clk;
    logic        rst_n;
    logic        idle_low_cfg;
    logic        spi_cs_n;
    logic        spi_clk;
    logic        spi_din;
    logic        spi_dout;
    logic        spi_dout_oe;
    logic        wr_valid;
    logic [6:0]  wr_area;
    logic [15:0] wr_addr;
    logic [23:0] wr_data;

    int errors = 0;
    int checks = 0;
    int wr_count = 0;
    bit done = 0;

    typedef struct packed {
        logic [6:0]  area;
        logic [15:0] addr;
        logic [23:0] data;
    } wr_t;

    wr_t  expq[$];
    logic hist[$];

    sctl_echo_slave u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_low_cfg (idle_low_cfg),
        .spi_cs_n     (spi_cs_n),
        .spi_clk      (spi_clk),
        .spi_din      (spi_din),
        .spi_dout     (spi_dout),
        .spi_dout_oe  (spi_dout_oe),
        .wr_valid     (wr_valid),
        .wr_area      (wr_area),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [6:0] area, input logic [15:0] addr, input logic [23:0] data);
        expq.push_back('{area: area, addr: addr, data: data});
    endtask

    // Monitor: compare each strobe with the next expected write (R4)
    always @(negedge clk) begin
        if (rst_n && wr_valid === 1'b1) begin
            wr_count++;
            if (expq.size() == 0) begin
                check(1'b0, "R4 unexpected write strobe", {wr_area, wr_addr, wr_data}, 64'h0);
            end else begin
                wr_t e;
                e = expq.pop_front();
                check({wr_area, wr_addr, wr_data} === e, "R4 write area/addr/data",
                      {wr_area, wr_addr, wr_data}, e);
            end
        end
    end

    // One serial bit: low phase, echo check, high phase (R7)
    task automatic send_bit(input logic b);
        logic exp;
        spi_din = b;
        spi_clk = 1'b0;
        repeat (4) @(negedge clk);
        exp = (hist.size() >= 8) ? hist[hist.size() - 8] : 1'b0;
        check(spi_dout === exp && spi_dout_oe === 1'b1, "R7 echo bit", {spi_dout_oe, spi_dout}, {1'b1, exp});
        spi_clk = 1'b1;
        repeat (4) @(negedge clk);
        hist.push_back(b);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic begin_frame();
        hist.delete();
        spi_cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic end_frame();
        spi_clk = 1'b0;
        repeat (3) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_drained(input string tag);
        check(expq.size() == 0, tag, expq.size(), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n0;
        rst_n        = 1'b0;
        idle_low_cfg = 1'b0;
        spi_cs_n     = 1'b1;
        spi_clk      = 1'b0;
        spi_din      = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Reset state and idle level (R8)
        check(spi_dout_oe === 1'b0 && spi_dout === 1'b0, "R8 idle released", {spi_dout_oe, spi_dout}, 2'b00);
        check(wr_valid === 1'b0, "R8 no strobe after reset", wr_valid, 0);
        idle_low_cfg = 1'b1;
        repeat (2) @(negedge clk);
        check(spi_dout_oe === 1'b1 && spi_dout === 1'b0, "R8 idle driven low", {spi_dout_oe, spi_dout}, 2'b10);

        // 24-bit burst with 8 trailing bits: R1 R3 R4 R7
        expect_wr(7'h34, 16'h0010, 24'hA5C3F0);
        expect_wr(7'h34, 16'h0011, 24'h123456);
        begin_frame();
        send_bits(32'hB4, 8);
        send_bits(32'h0010, 16);
        send_bits(32'hA5C3F0, 24);
        send_bits(32'h123456, 24);
        send_bits(32'h00, 8);
        end_frame();
        check_drained("R3 long burst writes seen");

        // Idle after a frame with drive-low config (R8)
        check(spi_dout_oe === 1'b1 && spi_dout === 1'b0, "R8 idle low after frame", {spi_dout_oe, spi_dout}, 2'b10);
        idle_low_cfg = 1'b0;

        // 16-bit burst across the address wrap plus a full trailing word: R2 R4 R6
        expect_wr(7'h35, 16'hFFFE, 24'h00BEEF);
        expect_wr(7'h35, 16'hFFFF, 24'h001234);
        expect_wr(7'h35, 16'h0000, 24'h0000FF);
        begin_frame();
        send_bits(32'hB5, 8);
        send_bits(32'hFFFE, 16);
        send_bits(32'hBEEF, 16);
        send_bits(32'h1234, 16);
        send_bits(32'h00FF, 16);
        end_frame();
        check_drained("R6 trailing word and wrap writes seen");
        check(spi_dout_oe === 1'b0, "R8 idle released after frame", spi_dout_oe, 0);

        // Partial word discarded (R5)
        n0 = wr_count;
        expect_wr(7'h34, 16'h0200, 24'h0F0F0F);
        begin_frame();
        send_bits(32'hB4, 8);
        send_bits(32'h0200, 16);
        send_bits(32'h0F0F0F, 24);
        send_bits(32'hABC, 12);
        end_frame();
        check(wr_count - n0 == 1, "R5 partial word gives no strobe", wr_count - n0, 1);
        check_drained("R5 full word written");

        // Read frame: no strobes (R1)
        n0 = wr_count;
        begin_frame();
        send_bits(32'h34, 8);
        send_bits(32'h0001, 16);
        send_bits(32'hC0FFEE, 24);
        send_bits(32'h765432, 24);
        end_frame();
        check(wr_count == n0, "R1 read frame writes nothing", wr_count - n0, 0);

        // Unassigned area: nothing written (R2)
        n0 = wr_count;
        begin_frame();
        send_bits(32'hAA, 8);
        send_bits(32'h12345678, 32);
        send_bits(32'h9A, 8);
        end_frame();
        check(wr_count == n0, "R2 unassigned area writes nothing", wr_count - n0, 0);

        // Abort mid-command, then a clean frame (R9)
        begin_frame();
        send_bits(32'h16, 5);
        end_frame();
        expect_wr(7'h35, 16'h0040, 24'h005A5A);
        begin_frame();
        send_bits(32'hB5, 8);
        send_bits(32'h0040, 16);
        send_bits(32'h5A5A, 16);
        send_bits(32'h00, 8);
        end_frame();
        check_drained("R9 frame after abort decoded from command");

        repeat (4) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule